// File: doc/BRIEF.md
# SPI Slave FPGA Configuration Sequencer

This block runs on the host side and loads a configuration image into an SRAM-based FPGA whose configuration port works as an SPI slave. It drives the target's active-low reset, its chip select, the serial clock and the serial data line, and it watches the target's done flag. Image bytes come in on a valid/ready stream, and a last marker flags the final byte.

A start request first checks the request and the serial clock divider. The block then holds the target in reset with chip select low for a fixed time, and checks that the done flag is low once reset is released. It keeps chip select low through a housekeeping wait and releases it before any data goes out. It then shifts out the image in SPI mode 0, checks that the done flag has risen, and clocks out zero bytes so the loaded design starts. Busy, done and latched error status are reported, along with a live "operating" indication that follows the done flag.

Top module: `fpga_cfg_loader`

## Requirements
- R1: A start request that passes its checks drives `creset_n_o` low and `cs_n_o` low in the same cycle, and keeps `creset_n_o` low for exactly RST_US microseconds of system clock cycles (CLK_HZ*RST_US/1e6). `busy_o` is high from then until the sequence ends.
- R2: In the first cycle after reset release, the block samples `done_i`. If it is high, the block stops with error code 2, releases chip select and sends no serial clock.
- R3: After reset release, chip select stays low for 1 + CLK_HZ*HK_US/1e6 more cycles. It then goes high, and stays high for at least one cycle before the first image byte starts.
- R4: The serial link uses mode 0. `sck_o` idles low whenever chip select is high, and `mosi_o` never changes while `sck_o` is high. The target samples on rising edges, bits go out most significant first, and the clock period is 2*`div_i` system cycles.
- R5: A start whose divider gives a clock outside 1 MHz to 25 MHz (CLK_HZ/(2*div)), or whose divider is zero, ends at once with error code 1 and no activity on the target pins.
- R6: If `done_i` is low in the cycle after the last image byte completes, the block stops with error code 3, releases chip select and sends no padding.
- R7: If `done_i` is high at that point, the block sends 7 all-zero bytes (56 clocks, which covers the required 49) with chip select still low. It then raises `done_o`, releases chip select and clears `busy_o`.
- R8: A start with `partial_i` high is rejected with error code 4, and neither reset nor chip select moves.
- R9: `op_o` is high exactly when `done_i` is high, in every state.
- R10: An error keeps `err_o` high and `err_code_o` stable until the next start request. An accepted start clears `err_o` in the following cycle. Code 0 means no error.
- R11: `s_ready_o` is high only while streaming with the shifter idle and the last byte not yet taken. After every handshake it drops for at least one cycle. Bytes reach the target in arrival order, one per serial frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a configuration run (taken when not busy) |
| partial_i | input | 1 | Start request asks for partial reconfiguration |
| div_i | input | DIV_W | Half-period of the serial clock in system cycles |
| s_data_i | input | 8 | Image byte |
| s_valid_i | input | 1 | Image byte valid |
| s_last_i | input | 1 | Image byte is the final one |
| s_ready_o | output | 1 | Block accepts an image byte |
| creset_n_o | output | 1 | Target reset, active low |
| cs_n_o | output | 1 | Target chip select, active low |
| sck_o | output | 1 | Serial clock to target |
| mosi_o | output | 1 | Serial data to target |
| done_i | input | 1 | Target configuration-done flag |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last run completed and the design was started |
| err_o | output | 1 | Latched error present |
| err_code_o | output | 3 | Error cause: 0 none, 1 divider, 2 reset, 3 not done, 4 partial |
| op_o | output | 1 | Target reports operating |

## Verification
The main run is tried three ways. The first uses a fast divider with a good done flag and a short varied image, which shows exact reset and housekeeping lengths, byte order and the 7 padding bytes. The second uses the slowest legal divider with the done flag left low, which separates the period computation from the pad path and shows that no padding follows a not-done error. The third holds the done flag high through reset and must abort before any clock is sent. Dividers one step outside each frequency limit, and a partial request, show that a rejected start leaves the target pins untouched.

// File: rtl/fpga_cfg_pkg.sv
package fpga_cfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RESET_HOLD,
        ST_CHECK_LOW,
        ST_HOUSEKEEP,
        ST_STREAM,
        ST_CHECK_DONE,
        ST_PAD,
        ST_DONE,
        ST_ERROR
    } cfg_state_e;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_DIV     = 3'd1,
        ERR_RESET   = 3'd2,
        ERR_NODONE  = 3'd3,
        ERR_PARTIAL = 3'd4
    } cfg_err_e;

    localparam int unsigned ACT_CLOCKS = 49;
    localparam int unsigned PAD_BYTES  = (ACT_CLOCKS + 7) / 8;
    localparam longint      SCK_MAX_HZ = 25_000_000;
    localparam longint      SCK_MIN_HZ = 1_000_000;

    // Serial clock is clk_hz / (2*div); legal band is inclusive.
    function automatic logic sck_div_ok(longint clk_hz, longint div);
        if (div == 0)
            return 1'b0;
        return (clk_hz <= 2 * div * SCK_MAX_HZ) && (clk_hz >= 2 * div * SCK_MIN_HZ);
    endfunction

    function automatic int unsigned us_to_cycles(longint clk_hz, longint us);
        return int'((clk_hz * us) / 1_000_000);
    endfunction

endpackage

// File: rtl/fpga_cfg_timer.sv
module fpga_cfg_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         zero_o
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load_i)
            cnt <= value_i;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);
endmodule

// File: rtl/fpga_cfg_shifter.sv
module fpga_cfg_shifter #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             load_i,
    input  logic [7:0]       byte_i,
    output logic             busy_o,
    output logic             sck_o,
    output logic             mosi_o
);
    logic [7:0]       shreg;
    logic [2:0]       bit_idx;
    logic [DIV_W-1:0] half_cnt;
    logic             busy;
    logic             sck;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            bit_idx  <= '0;
            half_cnt <= '0;
            busy     <= 1'b0;
            sck      <= 1'b0;
        end else if (load_i && !busy) begin
            shreg    <= byte_i;
            bit_idx  <= '0;
            half_cnt <= div_i - 1'b1;
            busy     <= 1'b1;
            sck      <= 1'b0;
        end else if (busy) begin
            if (half_cnt != '0) begin
                half_cnt <= half_cnt - 1'b1;
            end else begin
                half_cnt <= div_i - 1'b1;
                if (!sck) begin
                    sck <= 1'b1;
                end else begin
                    sck <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        busy  <= 1'b0;
                        shreg <= '0;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        shreg   <= {shreg[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign busy_o = busy;
    assign sck_o  = sck;
    assign mosi_o = busy & shreg[7];

    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
        sck_o |-> $stable(mosi_o)) else $error("mosi moved with sck high"); // R4
    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (load_i && !busy_o) |=> (busy_o && !sck_o)) else $error("load not taken"); // R11
endmodule

// File: rtl/fpga_cfg_loader.sv
module fpga_cfg_loader
    import fpga_cfg_pkg::*;
#(
    parameter int unsigned CLK_HZ = 125_000_000,
    parameter int unsigned RST_US = 1,
    parameter int unsigned HK_US  = 1200,
    parameter int unsigned DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             partial_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [7:0]       s_data_i,
    input  logic             s_valid_i,
    input  logic             s_last_i,
    output logic             s_ready_o,
    output logic             creset_n_o,
    output logic             cs_n_o,
    output logic             sck_o,
    output logic             mosi_o,
    input  logic             done_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [2:0]       err_code_o,
    output logic             op_o
);
    localparam int unsigned RST_CYC = us_to_cycles(CLK_HZ, RST_US);
    localparam int unsigned HK_CYC  = us_to_cycles(CLK_HZ, HK_US);
    localparam int unsigned MAX_CYC = (HK_CYC > RST_CYC) ? HK_CYC : RST_CYC;
    localparam int unsigned TW      = $clog2(MAX_CYC + 1) + 1;
    localparam int unsigned PW      = $clog2(PAD_BYTES + 1);

    cfg_state_e       state;
    cfg_err_e         err;
    logic [DIV_W-1:0] div_q;
    logic             last_seen;
    logic             cs_hold;
    logic [PW-1:0]    pad_left;

    logic             idle_like;
    logic             start_ok;
    logic             accept;
    logic             pad_load;
    logic             sh_load;
    logic [7:0]       sh_byte;
    logic             sh_busy;
    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_zero;

    assign idle_like = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_ERROR);
    assign start_ok  = idle_like && start_i && !partial_i
                       && sck_div_ok(longint'(CLK_HZ), longint'(div_i));
    assign s_ready_o = (state == ST_STREAM) && !sh_busy && !last_seen;
    assign accept    = s_valid_i && s_ready_o;
    assign pad_load  = (state == ST_PAD) && !sh_busy && (pad_left != '0);
    assign sh_load   = accept || pad_load;
    assign sh_byte   = (state == ST_STREAM) ? s_data_i : 8'h00;

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (start_ok) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(RST_CYC - 1);
        end else if (state == ST_CHECK_LOW && !done_i) begin
            tmr_load = 1'b1;
            tmr_val  = TW'(HK_CYC - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            err       <= ERR_NONE;
            div_q     <= DIV_W'(1);
            last_seen <= 1'b0;
            cs_hold   <= 1'b0;
            pad_left  <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE, ST_ERROR: begin
                    if (start_i) begin
                        last_seen <= 1'b0;
                        cs_hold   <= 1'b0;
                        if (partial_i) begin
                            err   <= ERR_PARTIAL;
                            state <= ST_ERROR;
                        end else if (!start_ok) begin
                            err   <= ERR_DIV;
                            state <= ST_ERROR;
                        end else begin
                            err   <= ERR_NONE;
                            div_q <= div_i;
                            state <= ST_RESET_HOLD;
                        end
                    end
                end
                ST_RESET_HOLD: if (tmr_zero) state <= ST_CHECK_LOW;
                ST_CHECK_LOW: begin
                    if (done_i) begin
                        err   <= ERR_RESET;
                        state <= ST_ERROR;
                    end else begin
                        state <= ST_HOUSEKEEP;
                    end
                end
                ST_HOUSEKEEP: if (tmr_zero) state <= ST_STREAM;
                ST_STREAM: begin
                    if (accept) begin
                        cs_hold <= 1'b1;
                        if (s_last_i) last_seen <= 1'b1;
                    end else if (last_seen && !sh_busy) begin
                        state <= ST_CHECK_DONE;
                    end
                end
                ST_CHECK_DONE: begin
                    if (done_i) begin
                        pad_left <= PW'(PAD_BYTES);
                        state    <= ST_PAD;
                    end else begin
                        err     <= ERR_NODONE;
                        cs_hold <= 1'b0;
                        state   <= ST_ERROR;
                    end
                end
                ST_PAD: begin
                    if (!sh_busy) begin
                        if (pad_left != '0) begin
                            pad_left <= pad_left - 1'b1;
                        end else begin
                            cs_hold <= 1'b0;
                            state   <= ST_DONE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    fpga_cfg_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load_i  (tmr_load),
        .value_i (tmr_val),
        .zero_o  (tmr_zero)
    );

    fpga_cfg_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .div_i  (div_q),
        .load_i (sh_load),
        .byte_i (sh_byte),
        .busy_o (sh_busy),
        .sck_o  (sck_o),
        .mosi_o (mosi_o)
    );

    assign creset_n_o = (state != ST_RESET_HOLD);
    assign cs_n_o     = !((state == ST_RESET_HOLD) || (state == ST_CHECK_LOW)
                          || (state == ST_HOUSEKEEP) || cs_hold);
    assign busy_o     = !idle_like;
    assign done_o     = (state == ST_DONE);
    assign err_o      = (err != ERR_NONE);
    assign err_code_o = err;
    assign op_o       = done_i;

    AST_CS_WITH_RESET: assert property (@(posedge clk) disable iff (rst)
        !creset_n_o |-> !cs_n_o) else $error("reset without chip select"); // R1
    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sck_o) else $error("clock active while deselected"); // R4
    AST_PARTIAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (start_i && partial_i && !busy_o) |=> (creset_n_o && cs_n_o && err_code_o == 3'd4))
        else $error("partial request not rejected"); // R8
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (err_o && !start_i) |=> (err_o && $stable(err_code_o))) else $error("error dropped"); // R10
    AST_ONE_PER_FRAME: assert property (@(posedge clk) disable iff (rst)
        (s_valid_i && s_ready_o) |=> !s_ready_o) else $error("second byte in a frame"); // R11
endmodule

// File: tb/fpga_cfg_loader_test.sv
module fpga_cfg_loader_test;
    localparam int unsigned CLK_HZ  = 125_000_000;
    localparam int unsigned RST_US  = 1;
    localparam int unsigned HK_US   = 2;
    localparam int unsigned RST_CYC = CLK_HZ / 1_000_000 * RST_US;
    localparam int unsigned HK_CYC  = CLK_HZ / 1_000_000 * HK_US;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic       partial_i = 1'b0;
    logic [7:0] div_i = 8'd3;
    logic [7:0] s_data_i = '0;
    logic       s_valid_i = 1'b0;
    logic       s_last_i = 1'b0;
    logic       done_i = 1'b0;
    logic       s_ready_o, creset_n_o, cs_n_o, sck_o, mosi_o;
    logic       busy_o, done_o, err_o, op_o;
    logic [2:0] err_code_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rx_cnt = 0;
    int cur_div = 3;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    fpga_cfg_loader #(.CLK_HZ(CLK_HZ), .RST_US(RST_US), .HK_US(HK_US), .DIV_W(8)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .partial_i(partial_i), .div_i(div_i),
        .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_last_i(s_last_i), .s_ready_o(s_ready_o),
        .creset_n_o(creset_n_o), .cs_n_o(cs_n_o), .sck_o(sck_o), .mosi_o(mosi_o),
        .done_i(done_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .err_code_o(err_code_o), .op_o(op_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Target model and scoreboard monitor: captures bits on rising clock.
    logic [7:0] rx_sh = '0;
    int         rx_bits = 0;
    int         last_rise = 0;
    always @(posedge sck_o) begin
        if (!cs_n_o) begin
            if (rx_bits != 0) chk("R4 sck period", cyc - last_rise, 2 * cur_div);
            last_rise = cyc;
            rx_sh = {rx_sh[6:0], mosi_o};
            rx_bits++;
            if (rx_bits == 8) begin
                rx_bits = 0;
                rx_cnt++;
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R11 unexpected byte actual %0d expected none", rx_sh);
                end else begin
                    chk("R11 byte order", int'(rx_sh), int'(exp_q.pop_front()));
                end
            end
        end else begin
            checks++;
            errors++;
            $display("FAIL R4 sck rose with cs high actual 1 expected 0");
        end
    end

    task automatic pulse_start(input logic part, input logic [7:0] d);
        @(negedge clk);
        partial_i = part;
        div_i     = d;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        partial_i = 1'b0;
    endtask

    task automatic send_image(input int n, input logic [7:0] seed, input logic raise_done);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = seed + 8'(i * 37);
            exp_q.push_back(b);
            s_data_i  = b;
            s_last_i  = (i == n - 1);
            s_valid_i = 1'b1;
            while (!s_ready_o) @(negedge clk);
            @(negedge clk);
            s_valid_i = 1'b0;
            s_last_i  = 1'b0;
        end
        done_i = raise_done;
    endtask

    task automatic measure_prelude(input string tag);
        int n_rst;
        int n_cs;
        n_rst = 0;
        chk("R1 cs low with reset", int'(cs_n_o), 0);
        chk("R1 busy", int'(busy_o), 1);
        while (!creset_n_o) begin n_rst++; @(negedge clk); end
        chk({tag, " R1 reset hold cycles"}, n_rst, RST_CYC);
        n_cs = 0;
        while (!cs_n_o) begin n_cs++; @(negedge clk); end
        chk({tag, " R3 housekeeping cycles"}, n_cs, 1 + HK_CYC);
        chk("R3 cs released before data", int'(cs_n_o), 1);
        chk("R3 no byte yet", rx_cnt, 0);
    endtask

    task automatic wait_idle(input int limit);
        int k;
        k = 0;
        while (busy_o && k < limit) begin k++; @(negedge clk); end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        int quiet;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        chk("R1 reset creset_n", int'(creset_n_o), 1);
        chk("R1 reset cs_n", int'(cs_n_o), 1);
        chk("R4 reset sck", int'(sck_o), 0);
        chk("R10 reset err", int'(err_o), 0);
        chk("R11 reset ready", int'(s_ready_o), 0);
        // R9 live status
        done_i = 1'b1; #1;
        chk("R9 op high", int'(op_o), 1);
        done_i = 1'b0; #1;
        chk("R9 op low", int'(op_o), 0);

        // R8 partial rejected, pins untouched
        pulse_start(1'b1, 8'd3);
        quiet = 1;
        for (int i = 0; i < 20; i++) begin
            if (!creset_n_o || !cs_n_o) quiet = 0;
            @(negedge clk);
        end
        chk("R8 pins quiet", quiet, 1);
        chk("R8 code", int'(err_code_o), 4);
        chk("R10 err latched", int'(err_o), 1);

        // R5 divider limits
        pulse_start(1'b0, 8'd2);
        chk("R5 div 2 code", int'(err_code_o), 1);
        chk("R5 div 2 reset idle", int'(creset_n_o), 1);
        pulse_start(1'b0, 8'd63);
        chk("R5 div 63 code", int'(err_code_o), 1);
        chk("R5 div 63 cs idle", int'(cs_n_o), 1);
        pulse_start(1'b0, 8'd0);
        chk("R5 div 0 code", int'(err_code_o), 1);

        // Good run, fast divider
        cur_div = 3;
        pulse_start(1'b0, 8'd3);
        chk("R10 err cleared by start", int'(err_o), 0);
        measure_prelude("run1");
        send_image(4, 8'h5A, 1'b1);
        for (int i = 0; i < 7; i++) exp_q.push_back(8'h00);
        wait_idle(5000);
        chk("R7 done_o", int'(done_o), 1);
        chk("R7 cs released", int'(cs_n_o), 1);
        chk("R7 byte count", rx_cnt, 11);
        chk("R7 queue empty", exp_q.size(), 0);
        chk("R7 no error", int'(err_code_o), 0);
        chk("R7 busy low", int'(busy_o), 0);

        // Slowest legal divider, done stays low
        done_i = 1'b0;
        cur_div = 62;
        base = rx_cnt;
        rx_cnt = 0;
        pulse_start(1'b0, 8'd62);
        chk("R5 div 62 accepted", int'(err_o), 0);
        measure_prelude("run2");
        send_image(2, 8'hC3, 1'b0);
        wait_idle(5000);
        repeat (200) @(negedge clk);
        chk("R6 code", int'(err_code_o), 3);
        chk("R6 cs released", int'(cs_n_o), 1);
        chk("R6 no padding", rx_cnt, 2);
        chk("R10 done_o low", int'(done_o), 0);

        // Done high across reset: reset failure
        cur_div = 3;
        rx_cnt = 0;
        done_i = 1'b1;
        pulse_start(1'b0, 8'd3);
        while (!creset_n_o) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R2 code", int'(err_code_o), 2);
        chk("R2 cs released", int'(cs_n_o), 1);
        repeat (100) @(negedge clk);
        chk("R2 no clocks", rx_cnt, 0);
        chk("R10 code stable", int'(err_code_o), 2);
        done_i = 1'b0;
        if (base < 0) $display("unused");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule